// File: doc/BRIEF.md
# Prioritized interrupt recognition controller

This block sits between seven active-low interrupt request lines and a processor's exception sequencer. It filters each line so that only a request seen low on two falling clock edges in a row counts. It compares the filtered requests with a 3-bit priority mask. It reports whether anything is waiting and which level is the highest one that qualifies. The top level (7) cannot be masked. It is detected as an event rather than as a level: a fresh assertion raises it, and so does a drop of the mask from 7 to a lower value while the line is still held.

Nothing is serviced at once. When the processor pulses its instruction-boundary strobe while a request is waiting, the block starts an acknowledge step. It drives a processor-space address that carries the granted level and raises a request to the bus. When the bus reports that the cycle is done, the block takes the 8-bit vector from the requester, loads the granted level into the mask and pulses a one-cycle "taken" indication. The processor can also load the mask directly, for example when it returns from a handler.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Input `irq_n[i]` is the request for level i+1. A line counts as asserted only after it has been sampled low on two consecutive falling clock edges. A low pulse that only one falling edge catches never shows as pending.
- R2: A qualified request at level 1 to 6 is eligible only when its level is strictly greater than `mask`. A mask of 0 blocks nothing. `pending` is 1 exactly when some level is eligible, and `pend_level` gives the highest eligible level (0 when none).
- R3: The pending level is not stored. `pend_level` follows the highest eligible level as requests come and go. A request at or below the mask, or one removed before it is acknowledged, leaves no effect.
- R4: Level 7 ignores the mask. A new assertion of its qualified line raises a level-7 event, and holding the line raises no further event. The detector re-arms only after the qualified line has been seen deasserted.
- R5: While the qualified level-7 line is held, a change of `mask` from 7 to any lower value raises a new level-7 event.
- R6: An acknowledge starts only when `boundary` is 1 while `pending` is 1. `ack_req` rises in the next cycle and stays 1 until the cycle in which `ack_done` is 1. Without the strobe, a waiting request never starts an acknowledge.
- R7: While `ack_req` is 1, `ack_addr` bits 23:4 are all ones, bits 3:1 hold the granted level and bit 0 is 1. A grant of level 4 therefore gives 24'hFFFFF9.
- R8: In the cycle after `ack_req` and `ack_done` are both 1, `irq_taken` is 1 for exactly one cycle. In that cycle `taken_vector` holds `ack_vector` as sampled with `ack_done`, and `taken_level` holds the granted level. `mask` now equals the granted level.
- R9: After reset, `mask` is 7 and `ack_req`, `irq_taken` and `pending` are 0.
- R10: `mask_we` loads `mask_wdata` into `mask` at the next edge. If an acknowledge completes in the same cycle, the granted level is loaded instead and the write is dropped.
- R11: A level-7 event stays pending after its line is released, until an acknowledge of level 7 completes. An event raised in that same completion cycle is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; requests are sampled on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 7 | Active-low requests, bit i is level i+1 |
| boundary | input | 1 | Instruction-boundary strobe |
| ack_done | input | 1 | Bus reports the acknowledge cycle complete |
| ack_vector | input | 8 | Vector returned by the requester |
| mask_we | input | 1 | Direct mask load enable |
| mask_wdata | input | 3 | Value for a direct mask load |
| mask | output | 3 | Current priority mask |
| pending | output | 1 | Some level is eligible for service |
| pend_level | output | 3 | Highest eligible level, 0 when none |
| ack_req | output | 1 | Acknowledge cycle requested |
| ack_addr | output | 24 | Processor-space acknowledge address |
| irq_taken | output | 1 | One-cycle pulse on acknowledge completion |
| taken_level | output | 3 | Level that was serviced |
| taken_vector | output | 8 | Vector captured on completion |

## Verification
Two updates can reach the mask in the same cycle: the completion of an acknowledge, and a direct mask load. The bench arranges this by raising `mask_we` with a low value in the very cycle its bus responder raises `ack_done`. A correct design shows the granted level in `mask` afterwards. A second collision occurs between the level-7 clear at completion and a new level-7 event. The reference model in the bench applies both, so any difference in `mask`, `pending` or `pend_level` on the following cycles counts as a mismatch.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic {
        ACK_IDLE = 1'b0,
        ACK_BUSY = 1'b1
    } ack_state_e;
endpackage

// File: rtl/irq_sampler.sv
// Two-sample qualifier: a line counts as asserted only when two
// consecutive falling-edge samples both see it low.
module irq_sampler #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_n,
    output logic [N-1:0] qual
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d    = smp_q;
        smp_d.s1 = ~req_n;
        smp_d.s2 = smp_q.s1;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    assign qual = smp_q.s1 & smp_q.s2;
endmodule

// File: rtl/irq_top_detect.sv
// Event detector for the non-maskable top level: a rising qualified
// line, or a mask leaving its all-ones value while the line is held.
module irq_top_detect #(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qual_top,
    input  logic [LVL_W-1:0] mask,
    input  logic             clr,
    output logic             pend
);
    typedef struct packed {
        logic armed;
        logic was_max;
        logic pend;
    } det_t;

    det_t det_d, det_q;
    logic new_edge;
    logic mask_drop;

    always_comb begin
        new_edge      = qual_top & det_q.armed;
        mask_drop     = qual_top & det_q.was_max & (mask != '1);
        det_d         = det_q;
        det_d.armed   = ~qual_top;
        det_d.was_max = (mask == '1);
        det_d.pend    = (det_q.pend & ~clr) | new_edge | mask_drop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '{armed: 1'b1, was_max: 1'b1, pend: 1'b0};
        else        det_q <= det_d;
    end

    assign pend = det_q.pend;
endmodule

// File: rtl/irq_prio_enc.sv
// Picks the highest eligible level; the top level overrides the mask.
module irq_prio_enc #(
    parameter int N_LVL = 7,
    parameter int LVL_W = 3
) (
    input  logic [N_LVL-2:0] qual_low,
    input  logic             top_pend,
    input  logic [LVL_W-1:0] mask,
    output logic             any,
    output logic [LVL_W-1:0] level
);
    always_comb begin
        level = '0;
        for (int l = 1; l < N_LVL; l++) begin
            if (qual_low[l-1] && (LVL_W'(l) > mask)) level = LVL_W'(l);
        end
        if (top_pend) level = LVL_W'(N_LVL);
        any = (level != '0);
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
    parameter int N_LVL  = 7,
    parameter int ADDR_W = 24,
    parameter int VEC_W  = 8,
    localparam int LVL_W = $clog2(N_LVL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_LVL-1:0]  irq_n,
    input  logic              boundary,
    input  logic              ack_done,
    input  logic [VEC_W-1:0]  ack_vector,
    input  logic              mask_we,
    input  logic [LVL_W-1:0]  mask_wdata,
    output logic [LVL_W-1:0]  mask,
    output logic              pending,
    output logic [LVL_W-1:0]  pend_level,
    output logic              ack_req,
    output logic [ADDR_W-1:0] ack_addr,
    output logic              irq_taken,
    output logic [LVL_W-1:0]  taken_level,
    output logic [VEC_W-1:0]  taken_vector
);
    import irq_pkg::*;

    localparam int PAD_W = ADDR_W - LVL_W - 1;
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(N_LVL);

    typedef struct packed {
        ack_state_e       st;
        logic [LVL_W-1:0] grant;
        logic [LVL_W-1:0] mask;
        logic             taken;
        logic [LVL_W-1:0] tlvl;
        logic [VEC_W-1:0] tvec;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [N_LVL-1:0] qual;
    logic             top_pend;
    logic             top_clr;
    logic             done_now;
    logic             any;
    logic [LVL_W-1:0] best;

    irq_sampler #(.N(N_LVL)) u_smp (
        .clk   (clk),
        .rst_n (rst_n),
        .req_n (irq_n),
        .qual  (qual)
    );

    irq_top_detect #(.LVL_W(LVL_W)) u_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .qual_top (qual[N_LVL-1]),
        .mask     (ctl_q.mask),
        .clr      (top_clr),
        .pend     (top_pend)
    );

    irq_prio_enc #(.N_LVL(N_LVL), .LVL_W(LVL_W)) u_enc (
        .qual_low (qual[N_LVL-2:0]),
        .top_pend (top_pend),
        .mask     (ctl_q.mask),
        .any      (any),
        .level    (best)
    );

    assign done_now = (ctl_q.st == ACK_BUSY) && ack_done;
    assign top_clr  = done_now && (ctl_q.grant == TOP_LVL);

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.taken = 1'b0;
        if (mask_we) ctl_d.mask = mask_wdata;
        unique case (ctl_q.st)
            ACK_IDLE: begin
                if (boundary && any) begin
                    ctl_d.st    = ACK_BUSY;
                    ctl_d.grant = best;
                end
            end
            ACK_BUSY: begin
                if (ack_done) begin
                    ctl_d.st    = ACK_IDLE;
                    ctl_d.taken = 1'b1;
                    ctl_d.tlvl  = ctl_q.grant;
                    ctl_d.tvec  = ack_vector;
                    ctl_d.mask  = ctl_q.grant;
                end
            end
            default: ctl_d.st = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ACK_IDLE, grant: '0, mask: '1, taken: 1'b0,
                       tlvl: '0, tvec: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mask         = ctl_q.mask;
    assign pending      = any;
    assign pend_level   = best;
    assign ack_req      = (ctl_q.st == ACK_BUSY);
    assign ack_addr     = {{PAD_W{1'b1}}, ctl_q.grant, 1'b1};
    assign irq_taken    = ctl_q.taken;
    assign taken_level  = ctl_q.tlvl;
    assign taken_vector = ctl_q.tvec;
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk #(
    parameter int LVL_W  = 3,
    parameter int ADDR_W = 24,
    parameter int VEC_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              boundary,
    input logic              ack_done,
    input logic [LVL_W-1:0]  mask,
    input logic              pending,
    input logic [LVL_W-1:0]  pend_level,
    input logic              ack_req,
    input logic [ADDR_W-1:0] ack_addr,
    input logic              irq_taken,
    input logic [LVL_W-1:0]  taken_level
);
    AST_PEND_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && pend_level != '1) |-> (pend_level > mask)); // R2

    AST_START_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_req) |-> $past(boundary && pending)); // R6

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !ack_done) |=> ack_req); // R6

    AST_ADDR_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |-> ((ack_addr[ADDR_W-1:LVL_W+1] == '1) && ack_addr[0])); // R7

    AST_TAKEN_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |-> $past(ack_req && ack_done)); // R8

    AST_TAKEN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |=> !irq_taken); // R8

    AST_MASK_ON_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |-> (mask == taken_level)); // R8
endmodule

bind irq_prio_ctrl irq_prio_chk #(.LVL_W(LVL_W), .ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .boundary    (boundary),
    .ack_done    (ack_done),
    .mask        (mask),
    .pending     (pending),
    .pend_level  (pend_level),
    .ack_req     (ack_req),
    .ack_addr    (ack_addr),
    .irq_taken   (irq_taken),
    .taken_level (taken_level)
);

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  irq_n = 7'h7F;
    logic        boundary = 1'b0;
    logic        ack_done = 1'b0;
    logic [7:0]  ack_vector = 8'h00;
    logic        mask_we = 1'b0;
    logic [2:0]  mask_wdata = 3'd0;
    logic [2:0]  mask;
    logic        pending;
    logic [2:0]  pend_level;
    logic        ack_req;
    logic [23:0] ack_addr;
    logic        irq_taken;
    logic [2:0]  taken_level;
    logic [7:0]  taken_vector;

    irq_prio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .boundary(boundary),
        .ack_done(ack_done), .ack_vector(ack_vector), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .mask(mask), .pending(pending),
        .pend_level(pend_level), .ack_req(ack_req), .ack_addr(ack_addr),
        .irq_taken(irq_taken), .taken_level(taken_level),
        .taken_vector(taken_vector)
    );

    always #10 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // ---------------- behavioural reference model ----------------
    logic [6:0] m_s1 = '0, m_s2 = '0;
    int  m_mask = 7, m_grant = 0, m_tlvl = 0, m_tvec = 0;
    bit  m_busy = 0, m_taken = 0, m_nmi = 0, m_armed = 1, m_prev7 = 1;

    function automatic int model_level();
        int best = 0;
        for (int l = 1; l <= 6; l++)
            if ((m_s1[l-1] && m_s2[l-1]) && l > m_mask) best = l;
        if (m_nmi) best = 7;
        return best;
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin m_s1 = '0; m_s2 = '0; end
        else begin m_s2 = m_s1; m_s1 = ~irq_n; end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask = 7; m_grant = 0; m_tlvl = 0; m_tvec = 0;
            m_busy = 0; m_taken = 0; m_nmi = 0; m_armed = 1; m_prev7 = 1;
        end else begin
            bit q7, done;
            int lvl, nmask;
            q7    = m_s1[6] && m_s2[6];
            lvl   = model_level();
            done  = m_busy && ack_done;
            m_nmi = (m_nmi && !(done && m_grant == 7)) || (q7 && m_armed)
                    || (q7 && m_prev7 && m_mask != 7);
            m_armed = !q7;
            m_prev7 = (m_mask == 7);
            nmask   = m_mask;
            if (mask_we) nmask = int'(mask_wdata);
            m_taken = 0;
            if (!m_busy) begin
                if (boundary && lvl != 0) begin m_busy = 1; m_grant = lvl; end
            end else if (ack_done) begin
                m_busy = 0; m_taken = 1; m_tlvl = m_grant;
                m_tvec = int'(ack_vector); nmask = m_grant;
            end
            m_mask = nmask;
        end
    end

    // Compare every cycle, between the rising and the falling edge.
    initial begin
        forever begin
            @(posedge clk);
            #8;
            chk("R8/R10 mask", 32'(mask), 32'(m_mask));
            chk("R2 pending", 32'(pending), 32'(model_level() != 0));
            chk("R3 pend_level", 32'(pend_level), 32'(model_level()));
            chk("R6 ack_req", 32'(ack_req), 32'(m_busy));
            if (m_busy) chk("R7 ack_addr", 32'(ack_addr), 32'hFFFFF1 | 32'(m_grant << 1));
            chk("R8 irq_taken", 32'(irq_taken), 32'(m_taken));
            if (m_taken) begin
                chk("R8 taken_level", 32'(taken_level), 32'(m_tlvl));
                chk("R8 taken_vector", 32'(taken_vector), 32'(m_tvec));
            end
        end
    end

    // ---------------- stimulus with built-in bus responder ----------------
    int resp_delay = 1;
    int resp_cnt = 0;
    logic [7:0] next_vec = 8'h40;
    bit collide = 0;
    logic [2:0] collide_val = 3'd0;

    task automatic step();
        @(posedge clk);
        #2;
        mask_we  = 1'b0;
        boundary = 1'b0;
        ack_done = 1'b0;
        if (ack_req) begin
            if (resp_cnt >= resp_delay) begin
                ack_done = 1'b1;
                ack_vector = next_vec;
                resp_cnt = 0;
                if (collide) begin
                    mask_we = 1'b1; mask_wdata = collide_val; collide = 0;
                end
            end else resp_cnt++;
        end else resp_cnt = 0;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic write_mask(input logic [2:0] v);
        mask_we = 1'b1; mask_wdata = v; step();
    endtask

    task automatic wait_taken(input string tag, input logic [7:0] vec, input int lvl);
        bit seen = 0;
        for (int i = 0; i < 20 && !seen; i++) begin
            step();
            if (irq_taken) seen = 1;
        end
        chk({tag, " taken seen"}, 32'(seen), 32'd1);
        chk({tag, " taken vector"}, 32'(taken_vector), 32'(vec));
        chk({tag, " taken level"}, 32'(taken_level), 32'(lvl));
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired got=running exp=finished");
        finish_up();
    end

    initial begin
        steps(3);
        chk("R9 reset mask", 32'(mask), 32'd7);
        chk("R9 reset ack_req", 32'(ack_req), 32'd0);
        chk("R9 reset taken", 32'(irq_taken), 32'd0);
        chk("R9 reset pending", 32'(pending), 32'd0);
        rst_n = 1'b1;
        steps(2);

        // R1: one-cycle glitch on level 3 with nothing masked
        write_mask(3'd0);
        irq_n[2] = 1'b0; step();
        irq_n[2] = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R1 glitch not pending", 32'(pending), 32'd0);
        end

        // R2/R3: level 3 held, level 5 added then removed
        irq_n[2] = 1'b0; steps(3);
        chk("R2 level3 pending", 32'(pend_level), 32'd3);
        irq_n[4] = 1'b0; steps(3);
        chk("R3 higher wins", 32'(pend_level), 32'd5);
        irq_n[4] = 1'b1; steps(3);
        chk("R3 back to level3", 32'(pend_level), 32'd3);

        // R6/R8: acknowledge level 3
        next_vec = 8'h43; resp_delay = 2;
        boundary = 1'b1; step();
        chk("R6 ack_req rises", 32'(ack_req), 32'd1);
        wait_taken("R8 level3", 8'h43, 3);
        step();
        chk("R8 mask loaded", 32'(mask), 32'd3);
        chk("R2 at-mask blocked", 32'(pending), 32'd0);
        write_mask(3'd2); step();
        chk("R10 mask write", 32'(mask), 32'd2);
        chk("R2 above mask", 32'(pend_level), 32'd3);
        irq_n[2] = 1'b1; steps(3);

        // R4/R11: level 7 with full mask, released before service
        write_mask(3'd7);
        irq_n[6] = 1'b0; steps(4);
        chk("R4 nmi ignores mask", 32'(pend_level), 32'd7);
        irq_n[6] = 1'b1; steps(4);
        chk("R11 event kept", 32'(pend_level), 32'd7);
        next_vec = 8'h77; resp_delay = 0;
        boundary = 1'b1; step();
        wait_taken("R11 nmi", 8'h77, 7);
        step();
        chk("R11 cleared", 32'(pending), 32'd0);

        // R4/R5/R10: level 7 held across service, then mask drop
        steps(3);
        irq_n[6] = 1'b0; steps(4);
        next_vec = 8'h70;
        boundary = 1'b1; step();
        wait_taken("R4 held nmi", 8'h70, 7);
        steps(5);
        chk("R4 held no refire", 32'(pending), 32'd0);
        write_mask(3'd5); steps(2);
        chk("R5 mask drop refires", 32'(pend_level), 32'd7);
        next_vec = 8'h71; collide = 1; collide_val = 3'd1;
        boundary = 1'b1; step();
        wait_taken("R10 collide", 8'h71, 7);
        chk("R10 completion wins", 32'(mask), 32'd7);
        steps(3);
        chk("R4 still held no event", 32'(pending), 32'd0);

        // R4: release then reassert re-arms
        irq_n[6] = 1'b1; steps(4);
        irq_n[6] = 1'b0; steps(4);
        chk("R4 rearmed", 32'(pend_level), 32'd7);
        next_vec = 8'h72; resp_delay = 3;
        boundary = 1'b1; step();
        wait_taken("R4 rearm service", 8'h72, 7);
        irq_n[6] = 1'b1; steps(3);

        // R6: no strobe, no acknowledge; R7: address for level 4
        boundary = 1'b1; step();
        chk("R6 strobe with nothing", 32'(ack_req), 32'd0);
        write_mask(3'd0);
        irq_n[3] = 1'b0;
        for (int i = 0; i < 10; i++) begin
            step();
            chk("R6 no strobe no ack", 32'(ack_req), 32'd0);
        end
        next_vec = 8'h54; resp_delay = 4;
        boundary = 1'b1; step();
        chk("R7 ack address", 32'(ack_addr), 32'hFFFFF9);
        wait_taken("R7 level4", 8'h54, 4);
        irq_n[3] = 1'b1; steps(4);

        finish_up();
    end
endmodule